// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind the write side of a parallel NOR flash model. It reads bus writes as steps of multi-cycle command sequences. It keeps a write-phase counter, a latched command byte and an 8-bit status register. From these it performs the following operations on a small on-chip storage array:

- word programming
- whole-sector erase
- a counted buffered block write with a final confirm step
- status clearing
- lock and unlock acknowledgement

Any sequence it does not recognise sends it back to plain array reads.

The current read mode is exported as a 2-bit code so that a separate read formatter can decide what a read returns. The formatter also gets the status register and a registered word read port on the array. Writes carry an access size of 1, 2 or 4 bytes. The block turns each write into per-lane byte enables. A static parameter selects little-endian or big-endian lane order.

Top module: `pflash_cmd_seq`

## Requirements
- R1: After reset the phase output is 0, the mode output is 0 (array) and the status output is 0x80.
- R2: In phase 0, command byte (wr_data[7:0]) 0x00, 0xF0 or 0xFF selects mode 0 and keeps phase 0. Byte 0x50 clears the status to 0x00 and selects mode 0. While wr_en is low, phase, mode and status hold.
- R3: In phase 0, byte 0x70 selects mode 1 (status) and byte 0x90 selects mode 2 (identifier). In both cases phase stays 0.
- R4: In phase 0, byte 0x98 selects mode 3 (query) and moves to phase 1. In phase 1 under query, byte 0xFF returns to mode 0 and phase 0. Any other byte leaves mode 3 and phase 1 in place.
- R5: In phase 0, any byte not named in R2, R3, R4, R6, R8, R10 or R11 selects mode 0, keeps phase 0 and leaves status unchanged.
- R6: Phase-0 byte 0x20 at once sets every byte of the addressed sector to 0xFF, sets status bit 7 and moves to phase 1 in mode 1. The sector is the byte address with its low log2(SECTOR_BYTES) bits cleared. Other sectors are untouched. In phase 1, 0xD0 returns to phase 0. 0xFF or any other byte selects mode 0 and phase 0.
- R7: With read_only high, the erase of R6 leaves the array unchanged and sets status bits 5 and 7.
- R8: Phase-0 byte 0x10 or 0x40 moves to phase 1 in mode 1. The next write stores its data at its address and size, sets status bit 7 and returns to phase 0.
- R9: With read_only high, the program step of R8 and the data steps of R11 store nothing and set status bit 4 as well as bit 7.
- R10: Phase-0 byte 0x60 moves to phase 1. In phase 1, 0xD0 or 0x01 sets status bit 7 and returns to phase 0 with mode 1 kept. Any other byte selects mode 0 and phase 0.
- R11: Phase-0 byte 0xE8 sets status bit 7 and moves to phase 1. The next write's data is masked to 8·DEV_BYTES bits (8·BANK_BYTES if DEV_BYTES is 0), loaded as count N, and the sequencer moves to phase 2. Phase 2 stores N+1 data writes and then moves to phase 3. In phase 3, 0xD0 returns to phase 0 with mode 1. Any other byte selects mode 0 and phase 0.
- R12: Lane order: word index is addr[ADDR_W-1:2], and byte address 4w+L is bits 8L+7:8L of array word w. wr_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, with naturally aligned addresses. In little-endian order, data byte k goes to byte address addr+k. In big-endian order, data byte n-1-k goes to addr+k, where n is the access size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wr_data | input | 32 | Write data; the command byte is bits 7:0 |
| read_only | input | 1 | Device is write-protected; stores and erases are refused |
| rd_addr | input | ADDR_W-2 | Word index for the array read port |
| rd_data | output | 32 | Array word, one cycle after rd_addr |
| mode | output | 2 | Read mode: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status register |
| phase | output | 2 | Write-phase counter of the sequence |

## Verification
The bench builds two instances that share one stimulus. The first is little-endian with DEV_BYTES=2 and BANK_BYTES=4. The second is big-endian with no device width set, so the count mask falls back to the 32-bit bank width. With both instances, a single buffered-write count of 0x00010002 makes the two sequencers end their data phase on different writes, which exercises the count masking. Every programmed word also exposes the two lane orders side by side. A 64-byte sector in a 256-byte array gives several sectors, so an erase can be shown to spare its neighbour.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } pfc_mode_e;

  localparam logic [7:0] C_ARRAY0  = 8'h00;
  localparam logic [7:0] C_PROG_A  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_ERASE_B = 8'h28;
  localparam logic [7:0] C_PROG_B  = 8'h40;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_BUFFER  = 8'hE8;
  localparam logic [7:0] C_ARRAY1  = 8'hF0;
  localparam logic [7:0] C_ARRAY2  = 8'hFF;
  localparam logic [7:0] C_UNLOCK  = 8'h01;

  // Mask of the low 'bits' bits of a 32-bit word.
  function automatic logic [31:0] low_mask(input int bits);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) if (i < bits) m[i] = 1'b1;
    return m;
  endfunction

  // Phase-0 command bytes with a defined meaning.
  function automatic logic known_first(input logic [7:0] c);
    return c inside {C_ARRAY0, C_ARRAY1, C_ARRAY2, C_CLEAR, C_STATUS,
                     C_IDENT, C_PROG_A, C_PROG_B, C_ERASE, C_LOCK,
                     C_QUERY, C_BUFFER};
  endfunction

endpackage

// File: rtl/pfc_lanes.sv
module pfc_lanes #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic [31:0] data,
  output logic [3:0]  lane_en,
  output logic [31:0] lane_data
);
  logic [1:0] base;
  int unsigned nbytes;

  always_comb begin
    case (size)
      2'd0:    begin nbytes = 1; base = addr_lo;             end
      2'd1:    begin nbytes = 2; base = {addr_lo[1], 1'b0}; end
      default: begin nbytes = 4; base = 2'd0;                end
    endcase
    lane_en   = '0;
    lane_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < nbytes) begin
        logic [1:0] lane;
        int src;
        lane = base + 2'(k);
        src  = BIG_ENDIAN ? (nbytes - 1 - k) : k;
        lane_en[lane] = 1'b1;
        lane_data[8*lane +: 8] = data[8*src +: 8];
      end
    end
  end
endmodule

// File: rtl/pfc_store.sv
module pfc_store #(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 64
) (
  input  logic              clk,
  input  logic              wr_word,
  input  logic              erase,
  input  logic [ADDR_W-3:0] wr_idx,
  input  logic [3:0]        lane_en,
  input  logic [31:0]       lane_data,
  input  logic [ADDR_W-3:0] rd_idx,
  output logic [31:0]       rd_data
);
  localparam int WORDS  = 1 << (ADDR_W - 2);
  localparam int SEC_SH = $clog2(SECTOR_BYTES) - 2;

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (erase && ((w >> SEC_SH) == (int'(wr_idx) >> SEC_SH))) begin
        mem[w] <= 32'hFFFF_FFFF;
      end else if (wr_word && (w == int'(wr_idx))) begin
        for (int b = 0; b < 4; b++)
          if (lane_en[b]) mem[w][8*b +: 8] <= lane_data[8*b +: 8];
      end
    end
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int BANK_BYTES = 4,
  parameter int DEV_BYTES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        read_only,
  output logic [1:0]  phase,
  output logic [7:0]  status,
  output pfc_mode_e   mode,
  output logic        st_write,
  output logic        st_erase
);
  localparam int          CNT_BYTES = (DEV_BYTES != 0) ? DEV_BYTES : BANK_BYTES;
  localparam logic [31:0] CNT_MASK  = low_mask(8 * CNT_BYTES);

  logic [1:0]  phase_q, phase_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [7:0]  stat_q, stat_d;
  logic [31:0] cnt_q, cnt_d;
  logic        to_array;
  logic [7:0]  c;

  assign c = wr_data[7:0];

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    stat_d   = stat_q;
    cnt_d    = cnt_q;
    st_write = 1'b0;
    st_erase = 1'b0;
    to_array = 1'b0;
    if (wr_en) begin
      case (phase_q)
        2'd0: begin
          case (c)
            C_ARRAY0, C_ARRAY1, C_ARRAY2: to_array = 1'b1;
            C_CLEAR:  begin stat_d = 8'h00; to_array = 1'b1; end
            C_STATUS, C_IDENT: cmd_d = c;
            C_PROG_A, C_PROG_B, C_LOCK, C_QUERY: begin
              cmd_d = c; phase_d = 2'd1;
            end
            C_ERASE: begin
              cmd_d = c; phase_d = 2'd1;
              if (read_only) stat_d = stat_q | 8'hA0;
              else begin st_erase = 1'b1; stat_d = stat_q | 8'h80; end
            end
            C_BUFFER: begin
              cmd_d = c; phase_d = 2'd1; stat_d = stat_q | 8'h80;
            end
            default: to_array = 1'b1;
          endcase
        end
        2'd1: begin
          case (cmd_q)
            C_PROG_A, C_PROG_B: begin
              if (read_only) stat_d = stat_q | 8'h90;
              else begin st_write = 1'b1; stat_d = stat_q | 8'h80; end
              phase_d = 2'd0;
            end
            C_ERASE, C_ERASE_B: begin
              if (c == C_CONFIRM) begin phase_d = 2'd0; stat_d = stat_q | 8'h80; end
              else to_array = 1'b1;
            end
            C_LOCK: begin
              if (c == C_CONFIRM || c == C_UNLOCK) begin
                phase_d = 2'd0; stat_d = stat_q | 8'h80;
              end else to_array = 1'b1;
            end
            C_BUFFER: begin cnt_d = wr_data & CNT_MASK; phase_d = 2'd2; end
            C_QUERY:  if (c == C_ARRAY2) to_array = 1'b1;
            default:  to_array = 1'b1;
          endcase
        end
        2'd2: begin
          if (cmd_q == C_BUFFER) begin
            if (read_only) stat_d = stat_q | 8'h90;
            else begin st_write = 1'b1; stat_d = stat_q | 8'h80; end
            if (cnt_q == '0) phase_d = 2'd3;
            cnt_d = cnt_q - 32'd1;
          end else to_array = 1'b1;
        end
        default: begin
          if (cmd_q == C_BUFFER && c == C_CONFIRM) begin
            phase_d = 2'd0; stat_d = stat_q | 8'h80;
          end else to_array = 1'b1;
        end
      endcase
      if (to_array) begin
        phase_d = 2'd0;
        cmd_d   = C_ARRAY0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      cmd_q   <= C_ARRAY0;
      stat_q  <= 8'h80;
      cnt_q   <= '0;
    end else if (wr_en) begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      stat_q  <= stat_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (cmd_q)
      C_ARRAY0: mode = MODE_ARRAY;
      C_IDENT:  mode = MODE_IDENT;
      C_QUERY:  mode = MODE_QUERY;
      default:  mode = MODE_STATUS;
    endcase
  end

  assign phase  = phase_q;
  assign status = stat_q;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(phase) && $stable(mode) && $stable(status));
  p_status_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && phase == 2'd0 && wr_data[7:0] == C_STATUS |=> mode == MODE_STATUS && phase == 2'd0);
  p_unknown_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && phase == 2'd0 && !known_first(wr_data[7:0]) |=> mode == MODE_ARRAY && phase == 2'd0 && $stable(status));
  p_prog_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && phase == 2'd1 && (cmd_q == C_PROG_A || cmd_q == C_PROG_B) |=> status[7] && phase == 2'd0);
  p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && phase == 2'd2 && cnt_q != '0 |=> phase == 2'd2);
  p_confirm_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && phase == 2'd3 |=> phase == 2'd0);
endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pfc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 64,
  parameter int BANK_BYTES   = 4,
  parameter int DEV_BYTES    = 2,
  parameter bit BIG_ENDIAN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  input  logic              read_only,
  input  logic [ADDR_W-3:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [1:0]        mode,
  output logic [7:0]        status,
  output logic [1:0]        phase
);
  logic [1:0]  rst_sync;
  logic        rst_ok;
  logic        st_write, st_erase;
  logic [3:0]  lane_en;
  logic [31:0] lane_data;
  pfc_mode_e   mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  pfc_seq #(.BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_ok), .wr_en(wr_en), .wr_data(wr_data),
    .read_only(read_only), .phase(phase), .status(status), .mode(mode_e),
    .st_write(st_write), .st_erase(st_erase)
  );

  pfc_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_lanes (
    .addr_lo(wr_addr[1:0]), .size(wr_size), .data(wr_data),
    .lane_en(lane_en), .lane_data(lane_data)
  );

  pfc_store #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_store (
    .clk(clk), .wr_word(st_write), .erase(st_erase),
    .wr_idx(wr_addr[ADDR_W-1:2]), .lane_en(lane_en), .lane_data(lane_data),
    .rd_idx(rd_addr), .rd_data(rd_data)
  );

  assign mode = mode_e;
endmodule

// File: tb/tb_pflash_cmd_seq.sv
`timescale 1ns/1ps
module tb_pflash_cmd_seq;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0]    wr_size = '0;
  logic [31:0]   wr_data = '0;
  logic          read_only = 1'b0;
  logic [AW-3:0] rd_addr = '0;
  logic [31:0]   rd_le, rd_be;
  logic [1:0]    mode_le, mode_be, ph_le, ph_be;
  logic [7:0]    st_le, st_be;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pflash_cmd_seq #(.ADDR_W(AW), .SECTOR_BYTES(64), .BANK_BYTES(4),
                   .DEV_BYTES(2), .BIG_ENDIAN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .read_only(read_only),
    .rd_addr(rd_addr), .rd_data(rd_le), .mode(mode_le), .status(st_le),
    .phase(ph_le));

  pflash_cmd_seq #(.ADDR_W(AW), .SECTOR_BYTES(64), .BANK_BYTES(4),
                   .DEV_BYTES(0), .BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .read_only(read_only),
    .rd_addr(rd_addr), .rd_data(rd_be), .mode(mode_be), .status(st_be),
    .phase(ph_be));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    bw(8'h00, 2'd0, {24'h0, c});
  endtask

  task automatic rd(input int idx, output logic [31:0] le, output logic [31:0] be);
    @(negedge clk);
    rd_addr = idx[AW-3:0];
    @(negedge clk);
    le = rd_le; be = rd_be;
  endtask

  task automatic st(input string req, input logic [1:0] m, input logic [1:0] p);
    chk({req, " mode"}, {30'h0, mode_le}, {30'h0, m});
    chk({req, " phase"}, {30'h0, ph_le}, {30'h0, p});
    chk({req, " mode be"}, {30'h0, mode_be}, {30'h0, m});
    chk({req, " phase be"}, {30'h0, ph_be}, {30'h0, p});
  endtask

  task automatic t_reset();
    do_reset();
    st("R1", 2'd0, 2'd0);
    chk("R1 status", {24'h0, st_le}, 32'h80);
    chk("R1 status be", {24'h0, st_be}, 32'h80);
  endtask

  task automatic t_modes();
    do_reset();
    cmd(8'h70); st("R3 status entry", 2'd1, 2'd0);
    cmd(8'hFF); st("R2 FF", 2'd0, 2'd0);
    cmd(8'h90); st("R3 ident entry", 2'd2, 2'd0);
    cmd(8'hF0); st("R2 F0", 2'd0, 2'd0);
    cmd(8'h70);
    repeat (3) @(negedge clk);
    st("R2 idle hold", 2'd1, 2'd0);
    cmd(8'h00); st("R2 00", 2'd0, 2'd0);
    cmd(8'h50); st("R2 clear", 2'd0, 2'd0);
    chk("R2 clear status", {24'h0, st_le}, 32'h00);
  endtask

  task automatic t_unknown();
    do_reset();
    cmd(8'h70);
    cmd(8'h33); st("R5 unknown", 2'd0, 2'd0);
    chk("R5 status kept", {24'h0, st_le}, 32'h80);
  endtask

  task automatic t_query();
    do_reset();
    cmd(8'h98); st("R4 entry", 2'd3, 2'd1);
    cmd(8'h12); st("R4 stay", 2'd3, 2'd1);
    cmd(8'hFF); st("R4 exit", 2'd0, 2'd0);
  endtask

  task automatic t_erase_prog();
    logic [31:0] a, b;
    do_reset();
    read_only = 1'b0;
    bw(8'h05, 2'd0, 32'h20); st("R6 erase phase", 2'd1, 2'd1);
    chk("R6 ready", {24'h0, st_le}, 32'h80);
    cmd(8'hD0); st("R6 confirm", 2'd1, 2'd0);
    rd(0, a, b);  chk("R6 word0 ff", a, 32'hFFFF_FFFF);
    rd(15, a, b); chk("R6 word15 ff", b, 32'hFFFF_FFFF);
    cmd(8'h40); st("R8 prog entry", 2'd1, 2'd1);
    bw(8'h02, 2'd1, 32'h0000_BEEF); st("R8 prog done", 2'd1, 2'd0);
    chk("R8 ready", {24'h0, st_le}, 32'h80);
    cmd(8'h10);
    bw(8'h00, 2'd0, 32'h0000_005A);
    rd(0, a, b);
    chk("R8 R12 le word0", a, 32'hBEEF_FF5A);
    chk("R12 be word0", b, 32'hEFBE_FF5A);
    cmd(8'h40);
    bw(8'h04, 2'd2, 32'h1122_3344);
    rd(1, a, b);
    chk("R12 le word1", a, 32'h1122_3344);
    chk("R12 be word1", b, 32'h4433_2211);
    bw(8'h7F, 2'd0, 32'h20); cmd(8'hD0);
    rd(31, a, b); chk("R6 sector1 ff", a, 32'hFFFF_FFFF);
    rd(0, a, b);  chk("R6 sector0 kept", a, 32'hBEEF_FF5A);
    bw(8'h40, 2'd0, 32'h20); cmd(8'h55); st("R6 bad confirm", 2'd0, 2'd0);
    bw(8'h40, 2'd0, 32'h20); cmd(8'hFF); st("R6 FF cancel", 2'd0, 2'd0);
  endtask

  task automatic t_readonly();
    logic [31:0] a, b;
    read_only = 1'b1;
    cmd(8'h50);
    cmd(8'h20);
    chk("R7 ro erase status", {24'h0, st_le}, 32'hA0);
    cmd(8'hD0);
    rd(0, a, b); chk("R7 ro erase kept", a, 32'hBEEF_FF5A);
    cmd(8'h50);
    cmd(8'h40);
    bw(8'h00, 2'd1, 32'h0);
    chk("R9 ro prog status", {24'h0, st_le}, 32'h90);
    rd(0, a, b); chk("R9 ro prog kept", a, 32'hBEEF_FF5A);
    read_only = 1'b0;
  endtask

  task automatic t_lock();
    do_reset();
    cmd(8'h60); st("R10 entry", 2'd1, 2'd1);
    cmd(8'h01); st("R10 unlock", 2'd1, 2'd0);
    cmd(8'h60); cmd(8'hD0); st("R10 lock", 2'd1, 2'd0);
    cmd(8'h60); cmd(8'h77); st("R10 other", 2'd0, 2'd0);
  endtask

  task automatic t_buffer();
    logic [31:0] a, b;
    do_reset();
    cmd(8'h50);
    cmd(8'hE8);
    chk("R11 ready", {24'h0, st_le}, 32'h80);
    st("R11 entry", 2'd1, 2'd1);
    bw(8'h00, 2'd2, 32'h0001_0002); st("R11 count", 2'd1, 2'd2);
    bw(8'h40, 2'd2, 32'hA000_0000);
    bw(8'h44, 2'd2, 32'hA000_0001);
    chk("R11 hold le", {30'h0, ph_le}, 32'd2);
    bw(8'h48, 2'd2, 32'hA000_0002);
    chk("R11 masked count le", {30'h0, ph_le}, 32'd3);
    chk("R11 bank mask be", {30'h0, ph_be}, 32'd2);
    rd(16, a, b); chk("R11 data0", a, 32'hA000_0000);
    chk("R12 be data0", b, 32'h0000_00A0);
    rd(18, a, b); chk("R11 data2", a, 32'hA000_0002);
    chk("R12 be data2", b, 32'h0200_00A0);
    bw(8'h4C, 2'd0, 32'hD0);
    chk("R11 confirm phase", {30'h0, ph_le}, 32'd0);
    chk("R11 confirm mode", {30'h0, mode_le}, 32'd1);
    do_reset();
    cmd(8'hE8); cmd(8'h00);
    bw(8'h50, 2'd2, 32'h0);
    st("R11 count zero", 2'd1, 2'd3);
    cmd(8'h33); st("R11 abort", 2'd0, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_unknown();
    t_query();
    t_erase_prog();
    t_readonly();
    t_lock();
    t_buffer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule